// File: doc/BRIEF.md
# Multi-Region Address Remapper

This block sits on an instruction-fetch alias bus and maps fetch addresses into external memory. A bank of four programmable windows describes the mapping. Each window has a 2 MB aligned base on the alias side and a 2 MB aligned target on the external side. Each window also has a power-of-two size, an output master-port choice and an output burst-kind choice. A configuration port writes one whole window per cycle.

A lookup port accepts an address and returns the result one cycle later. The result is a hit flag, the index of the window that matched, the translated address, the chosen port and the burst kind. An address that lands in no window comes back unchanged with the hit flag low.

The block only decodes and translates addresses. Its state is the registered window configuration plus the registered result.

Top module: `addr_remap_unit`

## Requirements
- R1: After a synchronous reset every window is disabled and `rs_valid` is 0. A lookup made before any configuration write therefore misses.
- R2: `rs_valid` is high in exactly the cycle after a cycle in which `lk_valid` was sampled high, and low in every other cycle.
- R3: A window matches when address bits 28:21 equal the window base. The comparison ignores the low `size-1` bits of that field. Address bits 31:29 take no part in matching.
- R4: On a hit, `rs_addr[31:21]` is the window target, except that its low `size-1` bits come from the incoming address. `rs_addr[20:0]` always equals the incoming `lk_addr[20:0]`.
- R5: The size code gives a window span of 2 MB << (code-1), for codes 1 to 7. A window whose size code is 0 never matches.
- R6: A window whose enable bit is 0 never matches.
- R7: When several enabled windows match, the result comes from the one with the lowest index, and `rs_region` reports that index.
- R8: On a miss, `rs_hit`=0, `rs_addr` equals the incoming address, and `rs_port`, `rs_burst` and `rs_region` are all 0.
- R9: On a hit, `rs_port` is the window's port field (0 = first master, 1 = second master). `rs_burst` is the window's burst field (0 = wrapping, 1 = incrementing).
- R10: A configuration write affects lookups sampled at later edges only. A lookup sampled at the same edge as the write uses the old settings. A write changes only the window selected by `cfg_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write the selected window this cycle |
| cfg_sel | input | 2 | Window index to write |
| cfg_enable | input | 1 | Window enable |
| cfg_size | input | 3 | Size code, 0 invalid, 1..7 = 2 MB..128 MB |
| cfg_base | input | 8 | Alias-side base, address bits 28:21 |
| cfg_target | input | 11 | External target, address bits 31:21 |
| cfg_port | input | 1 | Output master select |
| cfg_burst | input | 1 | Output burst kind |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup address |
| rs_valid | output | 1 | Result valid |
| rs_hit | output | 1 | A window matched |
| rs_region | output | 2 | Index of the matching window |
| rs_addr | output | 32 | Translated or passed-through address |
| rs_port | output | 1 | Master select of the result |
| rs_burst | output | 1 | Burst kind of the result |

## Verification
The bench makes two windows overlap. A priority encoder that favours the highest index would report the wrong region and target on those addresses. It probes the address just past a 2 MB window and varies bits 31:29, so that an off-by-one size mask or comparing the full upper field produces false hits or misses. It writes a window in the same cycle as a lookup, and it disables windows and programs a zero size code. A design that forwards writes combinationally, or trusts size code 0 or a cleared enable bit, would translate addresses that must pass through.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int ADDR_W   = 32;
  localparam int GRAN_LSB = 21;
  localparam int BASE_W   = 8;
  localparam int SIZE_W   = 3;
  localparam int TGT_W    = ADDR_W - GRAN_LSB;

  typedef struct packed {
    logic              en;
    logic [SIZE_W-1:0] size;
    logic [BASE_W-1:0] base;
    logic [TGT_W-1:0]  target;
    logic              port;
    logic              burst;
  } win_cfg_t;
endpackage

// File: rtl/remap_cfg_bank.sv
module remap_cfg_bank
  import remap_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [IDX_W-1:0]             sel,
  input  win_cfg_t                     wdata,
  output win_cfg_t [NUM_REGIONS-1:0]   cfg_q
);
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[g] <= '0;
      end else if (we && (sel == IDX_W'(g))) begin
        cfg_q[g] <= wdata;
      end
    end
  end
endmodule

// File: rtl/remap_window_match.sv
module remap_window_match
  import remap_pkg::*;
(
  input  win_cfg_t          cfg,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] xaddr
);
  logic [BASE_W-1:0] low_mask;
  logic [TGT_W-1:0]  low_mask_x;
  logic [BASE_W-1:0] alias_field;

  always_comb begin
    low_mask    = BASE_W'(((32'd1 << cfg.size) - 32'd1) >> 1);
    low_mask_x  = TGT_W'(low_mask);
    alias_field = addr[GRAN_LSB+BASE_W-1:GRAN_LSB];
    hit   = cfg.en && (cfg.size != '0) &&
            (((alias_field ^ cfg.base) & ~low_mask) == '0);
    xaddr = {(cfg.target & ~low_mask_x) | (addr[ADDR_W-1:GRAN_LSB] & low_mask_x),
             addr[GRAN_LSB-1:0]};
  end
endmodule

// File: rtl/remap_prio_pick.sv
module remap_prio_pick
  import remap_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic [NUM_REGIONS-1:0]             hits,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] xaddrs,
  input  win_cfg_t [NUM_REGIONS-1:0]         cfgs,
  input  logic [ADDR_W-1:0]                  raw_addr,
  output logic                               any_hit,
  output logic [IDX_W-1:0]                   win_idx,
  output logic [ADDR_W-1:0]                  out_addr,
  output logic                               out_port,
  output logic                               out_burst
);
  always_comb begin
    any_hit   = 1'b0;
    win_idx   = '0;
    out_addr  = raw_addr;
    out_port  = 1'b0;
    out_burst = 1'b0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any_hit   = 1'b1;
        win_idx   = IDX_W'(i);
        out_addr  = xaddrs[i];
        out_port  = cfgs[i].port;
        out_burst = cfgs[i].burst;
      end
    end
  end
endmodule

// File: rtl/addr_remap_unit.sv
module addr_remap_unit
  import remap_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_sel,
  input  logic              cfg_enable,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [TGT_W-1:0]  cfg_target,
  input  logic              cfg_port,
  input  logic              cfg_burst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rs_valid,
  output logic              rs_hit,
  output logic [IDX_W-1:0]  rs_region,
  output logic [ADDR_W-1:0] rs_addr,
  output logic              rs_port,
  output logic              rs_burst
);
  win_cfg_t                             wdata;
  win_cfg_t [NUM_REGIONS-1:0]           cfg_q;
  logic [NUM_REGIONS-1:0]               hits;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0]   xaddrs;
  logic                                 any_hit;
  logic [IDX_W-1:0]                     win_idx;
  logic [ADDR_W-1:0]                    sel_addr;
  logic                                 sel_port;
  logic                                 sel_burst;

  always_comb begin
    wdata.en     = cfg_enable;
    wdata.size   = cfg_size;
    wdata.base   = cfg_base;
    wdata.target = cfg_target;
    wdata.port   = cfg_port;
    wdata.burst  = cfg_burst;
  end

  remap_cfg_bank #(.NUM_REGIONS(NUM_REGIONS)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (wdata),
    .cfg_q (cfg_q)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    remap_window_match u_match (
      .cfg   (cfg_q[g]),
      .addr  (lk_addr),
      .hit   (hits[g]),
      .xaddr (xaddrs[g])
    );
  end

  remap_prio_pick #(.NUM_REGIONS(NUM_REGIONS)) u_pick (
    .hits      (hits),
    .xaddrs    (xaddrs),
    .cfgs      (cfg_q),
    .raw_addr  (lk_addr),
    .any_hit   (any_hit),
    .win_idx   (win_idx),
    .out_addr  (sel_addr),
    .out_port  (sel_port),
    .out_burst (sel_burst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_valid  <= 1'b0;
      rs_hit    <= 1'b0;
      rs_region <= '0;
      rs_addr   <= '0;
      rs_port   <= 1'b0;
      rs_burst  <= 1'b0;
    end else begin
      rs_valid <= lk_valid;
      if (lk_valid) begin
        rs_hit    <= any_hit;
        rs_region <= win_idx;
        rs_addr   <= sel_addr;
        rs_port   <= sel_port;
        rs_burst  <= sel_burst;
      end
    end
  end
endmodule

// File: rtl/remap_checker.sv
module remap_checker
  import remap_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              rs_valid,
  input logic              rs_hit,
  input logic [IDX_W-1:0]  rs_region,
  input logic [ADDR_W-1:0] rs_addr,
  input logic              rs_port,
  input logic              rs_burst
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !rs_valid); // R1

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rs_valid); // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rs_valid); // R2

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (rs_addr[GRAN_LSB-1:0] == $past(lk_addr[GRAN_LSB-1:0]))); // R4

  AST_MISS_PASS: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (rs_hit || ((rs_addr == $past(lk_addr)) && !rs_port &&
                             !rs_burst && (rs_region == '0)))); // R8
endmodule

bind addr_remap_unit remap_checker #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lk_valid  (lk_valid),
  .lk_addr   (lk_addr),
  .rs_valid  (rs_valid),
  .rs_hit    (rs_hit),
  .rs_region (rs_region),
  .rs_addr   (rs_addr),
  .rs_port   (rs_port),
  .rs_burst  (rs_burst)
);

// File: tb/addr_remap_unit_tb.sv
`timescale 1ns/1ps
module addr_remap_unit_tb;
  localparam int NW = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic        cfg_enable;
  logic [2:0]  cfg_size;
  logic [7:0]  cfg_base;
  logic [10:0] cfg_target;
  logic        cfg_port;
  logic        cfg_burst;
  logic        lk_valid;
  logic [31:0] lk_addr;
  logic        rs_valid;
  logic        rs_hit;
  logic [1:0]  rs_region;
  logic [31:0] rs_addr;
  logic        rs_port;
  logic        rs_burst;

  always #2.5 clk = ~clk;

  addr_remap_unit #(.NUM_REGIONS(NW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_enable(cfg_enable), .cfg_size(cfg_size), .cfg_base(cfg_base),
    .cfg_target(cfg_target), .cfg_port(cfg_port), .cfg_burst(cfg_burst),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .rs_valid(rs_valid),
    .rs_hit(rs_hit), .rs_region(rs_region), .rs_addr(rs_addr),
    .rs_port(rs_port), .rs_burst(rs_burst)
  );

  typedef struct {
    logic        hit;
    logic [1:0]  region;
    logic [31:0] addr;
    logic        port;
    logic        burst;
    string       tag;
  } exp_t;

  exp_t  sb_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  logic        m_en[NW];
  logic [2:0]  m_size[NW];
  logic [7:0]  m_base[NW];
  logic [10:0] m_tgt[NW];
  logic        m_port[NW];
  logic        m_burst[NW];

  function automatic exp_t predict(logic [31:0] a, string tag);
    exp_t e;
    e.hit = 0; e.region = 0; e.addr = a; e.port = 0; e.burst = 0; e.tag = tag;
    for (int i = NW - 1; i >= 0; i--) begin
      logic [7:0] lm;
      lm = 8'((((32'd1 << m_size[i])) - 1) >> 1);
      if (m_en[i] && m_size[i] != 0 && (((a[28:21] ^ m_base[i]) & ~lm) == 0)) begin
        e.hit = 1; e.region = 2'(i);
        e.addr = {(m_tgt[i] & ~{3'b0, lm}) | (a[31:21] & {3'b0, lm}), a[20:0]};
        e.port = m_port[i]; e.burst = m_burst[i];
      end
    end
    return e;
  endfunction

  task automatic set_cfg(int idx, logic en, logic [2:0] sz, logic [7:0] b,
                         logic [10:0] t, logic p, logic bu);
    cfg_we = 1; cfg_sel = 2'(idx); cfg_enable = en; cfg_size = sz;
    cfg_base = b; cfg_target = t; cfg_port = p; cfg_burst = bu;
  endtask

  task automatic commit_cfg();
    m_en[cfg_sel] = cfg_enable; m_size[cfg_sel] = cfg_size;
    m_base[cfg_sel] = cfg_base; m_tgt[cfg_sel] = cfg_target;
    m_port[cfg_sel] = cfg_port; m_burst[cfg_sel] = cfg_burst;
  endtask

  task automatic write_win(int idx, logic en, logic [2:0] sz, logic [7:0] b,
                           logic [10:0] t, logic p, logic bu);
    set_cfg(idx, en, sz, b, t, p, bu);
    @(negedge clk);
    commit_cfg();
    cfg_we = 0;
  endtask

  task automatic lookup(logic [31:0] a, string tag);
    sb_q.push_back(predict(a, tag));
    lk_valid = 1; lk_addr = a;
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic fail(string tag, string what, logic [31:0] act, logic [31:0] exp);
    errors++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  // monitor: pops one expected item per result
  initial begin
    @(negedge clk);
    forever begin
      @(negedge clk);
      if (!rst && rs_valid) begin
        checks++;
        if (sb_q.size() == 0) begin
          fail("R2", "unexpected result", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          if (rs_hit !== e.hit) fail(e.tag, "hit", 32'(rs_hit), 32'(e.hit));
          else if (rs_addr !== e.addr) fail(e.tag, "addr", rs_addr, e.addr);
          else if (rs_region !== e.region) fail(e.tag, "region", 32'(rs_region), 32'(e.region));
          else if (rs_port !== e.port) fail(e.tag, "port", 32'(rs_port), 32'(e.port));
          else if (rs_burst !== e.burst) fail(e.tag, "burst", 32'(rs_burst), 32'(e.burst));
        end
      end
    end
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      checks++;
      fail("WDOG", "timeout", 32'd1, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) begin
      m_en[i] = 0; m_size[i] = 0; m_base[i] = 0; m_tgt[i] = 0;
      m_port[i] = 0; m_burst[i] = 0;
    end
    rst = 1; cfg_we = 0; cfg_sel = 0; cfg_enable = 0; cfg_size = 0;
    cfg_base = 0; cfg_target = 0; cfg_port = 0; cfg_burst = 0;
    lk_valid = 0; lk_addr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    checks++;
    if (rs_valid !== 1'b0) fail("R1", "valid after reset", 32'(rs_valid), 32'd0);

    lookup(32'h0800_1234, "R1");                // nothing configured -> miss
    lookup(32'hDEAD_BEEF, "R8");                // pass-through

    write_win(0, 1, 3'd1, 8'h40, 11'h480, 1, 0);
    lookup(32'h0800_1234, "R4");                // -> 0x9000_1234
    lookup(32'h081F_FFFF, "R3");                // last byte of 2 MB window
    lookup(32'h0820_0000, "R3");                // just past window: miss
    lookup(32'hE800_1234, "R3");                // bits 31:29 ignored
    lookup(32'h0800_0040, "R9");                // port 1, wrap

    write_win(1, 1, 3'd3, 8'h40, 11'h500, 0, 1);
    lookup(32'h0800_0004, "R7");                // both match, window 0 wins
    lookup(32'h0860_0010, "R4");                // only window 1, carried bits
    lookup(32'h0880_0000, "R5");                // past 8 MB span: miss

    write_win(0, 0, 3'd1, 8'h40, 11'h480, 1, 0);
    lookup(32'h0800_0004, "R6");                // window 0 disabled -> window 1

    write_win(2, 1, 3'd0, 8'h10, 11'h3FF, 1, 1);
    lookup(32'h0200_0000, "R5");                // size code 0 never hits

    write_win(3, 1, 3'd7, 8'h80, 11'h7C0, 1, 1);
    lookup(32'h1234_5678, "R5");                // 128 MB span
    lookup(32'h0FFF_FFFC, "R9");

    // same-edge write and lookup: lookup sees old settings
    sb_q.push_back(predict(32'h0200_0100, "R10"));
    set_cfg(2, 1, 3'd2, 8'h10, 11'h123, 0, 1);
    lk_valid = 1; lk_addr = 32'h0200_0100;
    @(negedge clk);
    commit_cfg();
    cfg_we = 0; lk_valid = 0;
    lookup(32'h0200_0100, "R10");               // now hits window 2
    lookup(32'h0860_0010, "R10");               // window 1 untouched

    @(negedge clk);                             // idle gap checks no result
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      a = $urandom();
      if (n % 3 == 0) a[28:21] = 8'h40 | 8'($urandom_range(0, 7));
      if (n % 37 == 0)
        write_win($urandom_range(0, 3), 1'($urandom()), 3'($urandom()),
                  8'($urandom()), 11'($urandom()), 1'($urandom()), 1'($urandom()));
      lookup(a, "R3");
    end

    repeat (3) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) fail("R2", "results missing", 32'(sb_q.size()), 32'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule